// File: doc/BRIEF.md
# I/O Port Configuration Lock Sequencer

This block guards the per-pin configuration of a 16-pin I/O port. It monitors bus accesses to one lock register and recognises a three-step key: a word write with the key bit set, then a word write with the key bit clear, then a word write with the key bit set again. All three writes must carry the same 16-bit pin pattern. When the third write lands, the pattern becomes the lock mask and the key flag rises. Both then hold until reset. Any step that breaks the key discards the partial sequence.

Configuration register files in the port take the lock mask and refuse writes to the fields of pins whose mask bit is set. To show this, the block contains one demonstration field of two bits per pin. That field sits at its own offset and honours the mask. Reads of the lock register return the key flag and the active mask. A read has no effect on the sequence.

The sequencer has four states. ST_IDLE means no key step has been seen. ST_GOT_ONE means the first key write was accepted and its pattern is held. ST_GOT_ZERO means the clearing write matched. ST_LOCKED is terminal. The transitions are:
- ST_IDLE to ST_GOT_ONE on a word write with key 1, which captures the pattern.
- ST_GOT_ONE to ST_GOT_ZERO on a word write with key 0 and a matching pattern.
- ST_GOT_ZERO to ST_LOCKED on a word write with key 1 and a matching pattern.
- ST_GOT_ONE or ST_GOT_ZERO back to ST_GOT_ONE on any other word write with key 1, which re-captures the pattern.
- ST_GOT_ONE or ST_GOT_ZERO back to ST_IDLE on any other write to the lock register.

Top module: `cfg_lock_unit`

## Requirements
- R1: After reset the lock mask is 0, the key flag is 0, the demo field is 0, and a read of the lock register (offset 0x1C) returns 0.
- R2: Three full-word writes to offset 0x1C must arrive in the order bit16=1, bit16=0, bit16=1, each with the same bits 15:0. One cycle after the third write, the key flag is 1 and the lock mask equals those bits. Before that, both stay 0.
- R3: If the second or third write carries a different bits 15:0 pattern, the sequence aborts and no lock takes effect.
- R4: A write whose key bit is wrong for its step aborts the sequence, and no lock takes effect. Examples are a second write with bit16=1 or a third write with bit16=0. A write with bit16=0 in ST_IDLE is ignored.
- R5: A write to the lock register with the full-word flag low never advances the sequence, and it aborts any sequence in progress.
- R6: An aborting full-word write with bit16=1 counts as a new first step with its own pattern.
- R7: Reads and writes to any other offset, and reads of the lock register, do not disturb a sequence in progress.
- R8: Once locked, the key flag and the mask keep their values until reset, whatever is written.
- R9: A read of offset 0x1C returns the mask in bits 15:0 and the key flag in bit 16. Bits 31:17 read 0.
- R10: A write to the demo field (offset 0x00) updates bits [2i+1:2i] only for pins i whose mask bit is 0. Before a lock, every pin updates.
- R11: Bits 31:17 of a lock register write are ignored. They do not affect the sequence.
- R12: Reset clears an established lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_word | input | 1 | High when the access is a full 32-bit word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 32 | Read data (combinational from the read strobe) |
| lock_mask | output | 16 | Per-pin freeze mask for the configuration registers |
| key_active | output | 1 | Lock established |
| field_q | output | 32 | Demo two-bit-per-pin configuration field |

## Verification
The bench targets the cases where a sequencer is easy to get almost right.

Restart handling:
- The bench sends a second key-1 write with a new pattern. A design that drops to idle there, instead of restarting, never locks on the later pattern.
- The bench sends a half-word write in the middle of a sequence. A design that ignores the word flag locks when it should not.

Timing of the lock:
- A mask loaded from the newest write data, rather than from the held pattern, or loaded one step early, shows up as a mask mismatch at the lock cycle.

Interference from other accesses:
- Reads and writes to other offsets are interleaved into a sequence. A design that resets its state on those never completes the key.

After the lock:
- Full key sequences are replayed once the lock is set. A mask that is not sticky changes under them.
- Demo-field writes follow the lock. A field that ignores the mask overwrites pins that are frozen.

Constrained random traffic over a small set of patterns covers the remaining interleavings. A bench model of the requirements checks that traffic.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GOT_ONE  = 2'd1,
        ST_GOT_ZERO = 2'd2,
        ST_LOCKED   = 2'd3
    } lock_state_e;

endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NPINS     = 16,
    parameter int unsigned LOCK_OFS  = 'h1C,
    parameter int unsigned FIELD_OFS = 'h00
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS:0]    key_and_pat,
    input  logic              bus_word,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              lock_wr_hit,
    output logic              lock_rd_hit,
    output logic              field_wr_hit,
    output logic              field_rd_hit,
    output logic              word_ok,
    output logic              key_bit,
    output logic [NPINS-1:0]  pattern
);
    logic at_lock;
    logic at_field;

    always_comb begin
        at_lock      = (bus_addr == ADDR_W'(LOCK_OFS));
        at_field     = (bus_addr == ADDR_W'(FIELD_OFS));
        lock_wr_hit  = bus_wr && at_lock;
        lock_rd_hit  = bus_rd && at_lock;
        field_wr_hit = bus_wr && at_field;
        field_rd_hit = bus_rd && at_field;
        word_ok      = bus_word;
        key_bit      = key_and_pat[NPINS];
        pattern      = key_and_pat[NPINS-1:0];
    end
endmodule

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
    import cfg_lock_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             word_ok,
    input  logic             key_bit,
    input  logic [NPINS-1:0] pattern,
    output logic [NPINS-1:0] lock_mask,
    output logic             key_active
);
    lock_state_e      state_q;
    lock_state_e      state_nx;
    logic [NPINS-1:0] pat_q;
    logic [NPINS-1:0] pat_nx;
    logic             step_one;
    logic             step_zero;
    logic             same_pat;

    always_comb begin
        step_one  = wr_hit && word_ok && key_bit;
        step_zero = wr_hit && word_ok && !key_bit;
        same_pat  = (pattern == pat_q);
        state_nx  = state_q;
        pat_nx    = pat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (step_one) begin
                    state_nx = ST_GOT_ONE;
                    pat_nx   = pattern;
                end
            end
            ST_GOT_ONE: begin
                if (step_zero && same_pat) begin
                    state_nx = ST_GOT_ZERO;
                end else if (step_one) begin
                    state_nx = ST_GOT_ONE;
                    pat_nx   = pattern;
                end else if (wr_hit) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_GOT_ZERO: begin
                if (step_one && same_pat) begin
                    state_nx = ST_LOCKED;
                end else if (step_one) begin
                    state_nx = ST_GOT_ONE;
                    pat_nx   = pattern;
                end else if (wr_hit) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_LOCKED: begin
                state_nx = ST_LOCKED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pat_q   <= '0;
        end else begin
            state_q <= state_nx;
            pat_q   <= pat_nx;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_mask  <= '0;
            key_active <= 1'b0;
        end else begin
            if ((state_q == ST_GOT_ZERO) && (state_nx == ST_LOCKED)) begin
                lock_mask <= pat_q;
            end
            key_active <= (state_nx == ST_LOCKED);
        end
    end
endmodule

// File: rtl/cfg_lock_field.sv
module cfg_lock_field #(
    parameter int unsigned NPINS   = 16,
    parameter int unsigned FIELD_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [NPINS*FIELD_W-1:0] wdata,
    input  logic [NPINS-1:0]         lock_mask,
    output logic [NPINS*FIELD_W-1:0] field_q
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field_q[i*FIELD_W +: FIELD_W] <= '0;
            end else if (wr_en && !lock_mask[i]) begin
                field_q[i*FIELD_W +: FIELD_W] <= wdata[i*FIELD_W +: FIELD_W];
            end
        end
    end
endmodule

// File: rtl/cfg_lock_unit.sv
module cfg_lock_unit #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NPINS     = 16,
    parameter int unsigned FIELD_W   = 2,
    parameter int unsigned LOCK_OFS  = 'h1C,
    parameter int unsigned FIELD_OFS = 'h00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     bus_word,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NPINS-1:0]         lock_mask,
    output logic                     key_active,
    output logic [NPINS*FIELD_W-1:0] field_q
);
    localparam int unsigned KEY_BIT    = NPINS;
    localparam int unsigned FIELD_BITS = NPINS * FIELD_W;

    logic             lock_wr_hit;
    logic             lock_rd_hit;
    logic             field_wr_hit;
    logic             field_rd_hit;
    logic             word_ok;
    logic             key_bit;
    logic [NPINS-1:0] pattern;

    cfg_lock_decode #(
        .ADDR_W(ADDR_W), .NPINS(NPINS), .LOCK_OFS(LOCK_OFS), .FIELD_OFS(FIELD_OFS)
    ) u_decode (
        .bus_addr    (bus_addr),
        .key_and_pat (bus_wdata[KEY_BIT:0]),
        .bus_word    (bus_word),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .lock_wr_hit (lock_wr_hit),
        .lock_rd_hit (lock_rd_hit),
        .field_wr_hit(field_wr_hit),
        .field_rd_hit(field_rd_hit),
        .word_ok     (word_ok),
        .key_bit     (key_bit),
        .pattern     (pattern)
    );

    cfg_lock_fsm #(.NPINS(NPINS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (lock_wr_hit),
        .word_ok   (word_ok),
        .key_bit   (key_bit),
        .pattern   (pattern),
        .lock_mask (lock_mask),
        .key_active(key_active)
    );

    cfg_lock_field #(.NPINS(NPINS), .FIELD_W(FIELD_W)) u_field (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (field_wr_hit),
        .wdata    (bus_wdata[FIELD_BITS-1:0]),
        .lock_mask(lock_mask),
        .field_q  (field_q)
    );

    always_comb begin
        rd_data = '0;
        if (lock_rd_hit) begin
            rd_data[NPINS-1:0] = lock_mask;
            rd_data[KEY_BIT]   = key_active;
        end else if (field_rd_hit) begin
            rd_data[FIELD_BITS-1:0] = field_q;
        end
    end
endmodule

// File: rtl/cfg_lock_checker.sv
module cfg_lock_checker #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NPINS    = 16,
    parameter int unsigned FIELD_W  = 2,
    parameter int unsigned LOCK_OFS = 'h1C
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic                     bus_word,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [DATA_W-1:0]        rd_data,
    input logic [NPINS-1:0]         lock_mask,
    input logic                     key_active,
    input logic [NPINS*FIELD_W-1:0] field_q
);
    logic [NPINS*FIELD_W-1:0] mask_x;
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            mask_x[i*FIELD_W +: FIELD_W] = {FIELD_W{lock_mask[i]}};
        end
    end

    assert_key_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_active |=> key_active);

    assert_mask_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_active |=> $stable(lock_mask));

    assert_mask_zero_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !key_active |-> (lock_mask == '0));

    assert_lock_by_word_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_active) |-> $past(bus_wr && bus_word && bus_wdata[NPINS]
                                    && (bus_addr == ADDR_W'(LOCK_OFS))));

    assert_mask_from_last_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_active) |-> (lock_mask == $past(bus_wdata[NPINS-1:0])));

    assert_frozen_pins_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (key_active && $past(key_active)) |-> (((field_q ^ $past(field_q)) & mask_x) == '0));

    assert_reserved_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == ADDR_W'(LOCK_OFS))) |-> (rd_data[DATA_W-1:NPINS+1] == '0));
endmodule

bind cfg_lock_unit cfg_lock_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPINS(NPINS), .FIELD_W(FIELD_W), .LOCK_OFS(LOCK_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_word(bus_word), .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_data(rd_data),
    .lock_mask(lock_mask), .key_active(key_active), .field_q(field_q)
);

// File: tb/cfg_lock_unit_bench.sv
`timescale 1ns/1ps
module cfg_lock_unit_bench;
    localparam logic [7:0] LOCK  = 8'h1C;
    localparam logic [7:0] FLD   = 8'h00;
    localparam logic [7:0] OTHER = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_word = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] rd_data;
    logic [15:0] lock_mask;
    logic        key_active;
    logic [31:0] field_q;

    int checks = 0;
    int errors = 0;

    // model of the requirements
    int          m_st;
    logic [15:0] m_pat;
    logic [15:0] m_mask;
    logic [31:0] m_field;

    always #2.5 clk = ~clk;

    cfg_lock_unit u_cfg_lock_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_word(bus_word), .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_data(rd_data),
        .lock_mask(lock_mask), .key_active(key_active), .field_q(field_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic w);
        logic        k;
        logic [15:0] p;
        k = d[16];
        p = d[15:0];
        if (a == LOCK) begin
            case (m_st)
                0: if (w && k) begin m_st = 1; m_pat = p; end
                1: if (w && !k && p == m_pat) m_st = 2;
                   else if (w && k) begin m_st = 1; m_pat = p; end
                   else m_st = 0;
                2: if (w && k && p == m_pat) begin m_st = 3; m_mask = p; end
                   else if (w && k) begin m_st = 1; m_pat = p; end
                   else m_st = 0;
                default: ;
            endcase
        end else if (a == FLD) begin
            for (int i = 0; i < 16; i++)
                if (!m_mask[i]) m_field[2*i +: 2] = d[2*i +: 2];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_st = 0; m_pat = '0; m_mask = '0; m_field = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic w);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b0;
        model_write(a, d, w);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic key(input logic [15:0] p, input logic k, input logic w);
        wr(LOCK, {15'b0, k, p}, w);
    endtask

    task automatic check_model(input string req);
        chk({req, " key"}, {31'b0, key_active}, {31'b0, m_st == 3});
        chk({req, " mask"}, {16'b0, lock_mask}, {16'b0, m_mask});
        chk({req, " field"}, field_q, m_field);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        do_reset();

        // R1 reset state
        chk("R1 key", {31'b0, key_active}, 32'd0);
        chk("R1 mask", {16'b0, lock_mask}, 32'd0);
        chk("R1 field", field_q, 32'd0);
        rd(LOCK, v); chk("R1 read", v, 32'd0);

        // R2 / R10 basic lock
        wr(FLD, 32'hFFFF_FFFF, 1'b1);
        chk("R10 unlocked field", field_q, 32'hFFFF_FFFF);
        key(16'h00A5, 1'b1, 1'b1);
        key(16'h00A5, 1'b0, 1'b1);
        chk("R2 not yet", {31'b0, key_active}, 32'd0);
        key(16'h00A5, 1'b1, 1'b1);
        chk("R2 key", {31'b0, key_active}, 32'd1);
        chk("R2 mask", {16'b0, lock_mask}, 32'h0000_00A5);
        rd(LOCK, v); chk("R9 read", v, 32'h0001_00A5);
        wr(FLD, 32'h0, 1'b1);
        chk("R10 locked field", field_q, 32'h0000_CC33);
        // R8 replay
        key(16'h1234, 1'b1, 1'b1); key(16'h1234, 1'b0, 1'b1); key(16'h1234, 1'b1, 1'b1);
        wr(LOCK, 32'h0000_0000, 1'b1);
        chk("R8 mask", {16'b0, lock_mask}, 32'h0000_00A5);
        chk("R8 key", {31'b0, key_active}, 32'd1);

        // R12 reset clears lock
        do_reset();
        chk("R12 key", {31'b0, key_active}, 32'd0);
        chk("R12 mask", {16'b0, lock_mask}, 32'd0);

        // R3 pattern change
        key(16'h0001, 1'b1, 1'b1); key(16'h0002, 1'b0, 1'b1); key(16'h0002, 1'b1, 1'b1);
        chk("R3 second", {31'b0, key_active}, 32'd0);
        key(16'h0003, 1'b0, 1'b1); key(16'h0004, 1'b1, 1'b1);
        check_model("R3 third");
        chk("R3 third key", {31'b0, key_active}, 32'd0);

        // R4 wrong key values
        do_reset();
        key(16'h0010, 1'b0, 1'b1); key(16'h0010, 1'b1, 1'b1); key(16'h0010, 1'b0, 1'b1);
        key(16'h0010, 1'b0, 1'b1); key(16'h0010, 1'b1, 1'b1);
        chk("R4 key", {31'b0, key_active}, 32'd0);

        // R5 non-word access
        do_reset();
        key(16'h0100, 1'b1, 1'b1); key(16'h0100, 1'b0, 1'b0); key(16'h0100, 1'b1, 1'b1);
        chk("R5 mid", {31'b0, key_active}, 32'd0);
        do_reset();
        key(16'h0100, 1'b1, 1'b1); key(16'h0100, 1'b0, 1'b1); key(16'h0100, 1'b1, 1'b0);
        chk("R5 last", {31'b0, key_active}, 32'd0);

        // R6 restart on key-one abort
        do_reset();
        key(16'h00F0, 1'b1, 1'b1); key(16'h0F00, 1'b1, 1'b1);
        key(16'h0F00, 1'b0, 1'b1); key(16'h0F00, 1'b1, 1'b1);
        chk("R6 mask", {16'b0, lock_mask}, 32'h0000_0F00);
        chk("R6 key", {31'b0, key_active}, 32'd1);

        // R7 interleaved traffic
        do_reset();
        key(16'h8001, 1'b1, 1'b1);
        rd(LOCK, v); wr(OTHER, 32'h0001_0000, 1'b1); wr(FLD, 32'h5555_5555, 1'b0);
        key(16'h8001, 1'b0, 1'b1);
        rd(FLD, v); chk("R7 field read", v, 32'h5555_5555);
        wr(OTHER, 32'hFFFF_FFFF, 1'b0);
        key(16'h8001, 1'b1, 1'b1);
        chk("R7 mask", {16'b0, lock_mask}, 32'h0000_8001);

        // R11 reserved bits ignored
        do_reset();
        wr(LOCK, 32'hFFFE_0000 | 32'h0001_0042, 1'b1);
        wr(LOCK, 32'hABCC_0000 | 32'h0000_0042, 1'b1);
        wr(LOCK, 32'h1232_0000 | 32'h0001_0042, 1'b1);
        chk("R11 mask", {16'b0, lock_mask}, 32'h0000_0042);
        rd(LOCK, v); chk("R11 R9 read", v, 32'h0001_0042);

        // constrained random
        for (int n = 0; n < 600; n++) begin
            int unsigned r;
            logic [15:0] p;
            logic [31:0] d;
            if (n % 150 == 0) do_reset();
            r = $urandom % 20;
            case ($urandom % 3)
                0: p = 16'h00A5;
                1: p = 16'h5A00;
                default: p = 16'hFFFF;
            endcase
            d = {$urandom, 16'h0} ^ {15'b0, 1'b0, p};
            d[15:0] = p;
            d[16] = $urandom % 2;
            if (r < 13) begin
                wr(LOCK, d, ($urandom % 8) != 0);
                check_model("R2 random");
            end else if (r < 16) begin
                wr(FLD, $urandom, ($urandom % 2) != 0);
                check_model("R10 random");
            end else if (r < 17) begin
                wr(OTHER, d, 1'b1);
                check_model("R7 random");
            end else begin
                rd(LOCK, v);
                chk("R9 random read", v, {15'b0, m_st == 3, m_mask});
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule